// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses of its beats, one per clock, for a DDR-style SDRAM read or write. A mode load programs the burst length (2, 4 or 8 beats) and the ordering (sequential or interleaved). A start pulse with a starting column then yields a run of beats. Every beat stays inside the aligned block whose size is the burst length. The column bits above that block never change.

The mode load also sorts the upper bits of the mode word. It recognises a DLL-reset load, a normal-operation load and reserved combinations. After a DLL-reset load a flag stays high until a normal-operation load follows. A load with a reserved length code or reserved upper bits is refused: the programmed setting is kept and an error flag is raised.

Top module: `burst_col_seq`

## Requirements
- R1: A mode load takes the burst length from bits 2:0 (code 1 = 2 beats, 2 = 4 beats, 3 = 8 beats) and the ordering from bit 3 (0 sequential, 1 interleaved).
- R2: During a burst, col_addr bits above the in-block offset equal those of the starting column, so the address wraps to the start of the aligned block rather than leaving it.
- R3: In sequential ordering, the in-block offset of beat i equals (start offset + i) modulo the burst length.
- R4: In interleaved ordering, the in-block offset of beat i equals the start offset XOR i.
- R5: When idle, a start gives its first beat in the next cycle, then one beat per cycle for exactly burst-length cycles. beat_last is high on the final beat only, and beat_valid is low in the cycle after it.
- R6: busy is high while beats are being issued. A start received while busy is ignored and leaves the running burst unchanged.
- R7: A mode load whose length code is 0 or 4 to 7 is rejected. Length, ordering and the DLL flag keep their values, and mode_err goes high and stays high until the next accepted load clears it.
- R8: An accepted load with bit 8 = 1, bit 7 = 0 and all bits above 8 zero sets dll_pending. An accepted load with bits 7 and up all zero clears dll_pending.
- R9: A mode load whose bits 7 and up match neither pattern of R8 is rejected exactly as in R7.
- R10: Length and ordering are captured when a burst starts. A mode load during a burst does not change that burst's addresses.
- R11: After reset the block is idle (beat_valid, beat_last and busy low), dll_pending and mode_err are low, and the setting is 4 beats, sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load mode_word this cycle |
| mode_word | input | MODE_W | Mode word: length code, ordering bit, upper control bits |
| start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column of the burst |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is being issued |
| beat_last | output | 1 | Final beat of the burst |
| busy | output | 1 | Burst in progress; start is ignored |
| dll_pending | output | 1 | DLL-reset load seen, normal load not yet seen |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The assertions assume that start and mode_load are single-cycle synchronous pulses. They also assume that mode_word is at least ten bits wide, so the DLL pattern can be decoded. The stimulus drives every input half a cycle away from the clock edge. It raises each pulse for exactly one cycle, and it issues starts during busy and mode loads mid-burst only as deliberate tests of R6 and R10. The sweep covers every length, ordering and in-block start offset, with both a zero and a nonzero upper column.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int BEAT_W = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_INT = 1'b1
    } order_e;

    // lg is log2 of the burst length: 1, 2 or 3
    typedef struct packed {
        logic [1:0] lg;
        order_e     ord;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{lg: 2'd2, ord: ORD_SEQ};

    function automatic logic [BEAT_W-1:0] offset_mask(input logic [1:0] lg);
        logic [BEAT_W:0] one_hot;
        one_hot = (BEAT_W+1)'(1) << lg;
        return BEAT_W'(one_hot - (BEAT_W+1)'(1));
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg,
    output logic              dll_pending,
    output logic              mode_err
);

    localparam int UP_LO = 7;

    typedef struct packed {
        burst_cfg_t cfg;
        logic       dll;
        logic       err;
    } mode_state_t;

    mode_state_t st_d, st_q;

    logic [2:0] len_code;
    logic       len_ok;
    logic       up_normal;
    logic       up_dll;
    logic       accept;

    always_comb begin
        len_code  = mode_word[2:0];
        len_ok    = (len_code == 3'd1) || (len_code == 3'd2) || (len_code == 3'd3);
        up_normal = (mode_word[MODE_W-1:UP_LO] == '0);
        up_dll    = mode_word[8] && !mode_word[7] && (mode_word[MODE_W-1:9] == '0);
        accept    = len_ok && (up_normal || up_dll);

        st_d = st_q;
        if (mode_load) begin
            if (accept) begin
                st_d.cfg.lg  = len_code[1:0];
                st_d.cfg.ord = order_e'(mode_word[3]);
                st_d.dll     = up_dll;
                st_d.err     = 1'b0;
            end else begin
                st_d.err     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cfg: CFG_RESET, dll: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg         = st_q.cfg;
    assign dll_pending = st_q.dll;
    assign mode_err    = st_q.err;

    // R7: a reserved length code raises the error flag and keeps the setting
    a_r7_bad_len: assert property (@(posedge clk) disable iff (rst)
        (mode_load && !len_ok) |=> (mode_err && $stable(cfg) && $stable(dll_pending)));

    // R9: reserved upper bits are refused the same way
    a_r9_bad_upper: assert property (@(posedge clk) disable iff (rst)
        (mode_load && !up_normal && !up_dll) |=> (mode_err && $stable(cfg)));

    // R8: DLL-reset load sets the pending flag, normal load clears it
    a_r8_dll_set: assert property (@(posedge clk) disable iff (rst)
        (mode_load && len_ok && up_dll) |=> dll_pending);
    a_r8_dll_clr: assert property (@(posedge clk) disable iff (rst)
        (mode_load && len_ok && up_normal) |=> !dll_pending);

    // R1: the stored length is never a reserved one
    a_r1_len_legal: assert property (@(posedge clk) disable iff (rst)
        cfg.lg != 2'd0);

endmodule

// File: rtl/bcs_order_gen.sv
module bcs_order_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] beat_idx,
    input  burst_cfg_t        cfg,
    output logic [COL_W-1:0]  col
);

    logic [BEAT_W-1:0] mask;
    logic [BEAT_W-1:0] start_off;
    logic [BEAT_W-1:0] off;

    always_comb begin
        mask      = offset_mask(cfg.lg);
        start_off = base_col[BEAT_W-1:0];
        if (cfg.ord == ORD_INT) begin
            off = start_off ^ beat_idx;
        end else begin
            off = start_off + beat_idx;
        end
        col = {base_col[COL_W-1:BEAT_W], (start_off & ~mask) | (off & mask)};
    end

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  burst_cfg_t        cur_cfg,
    output logic [COL_W-1:0]  base_col,
    output logic [BEAT_W-1:0] beat_idx,
    output burst_cfg_t        run_cfg,
    output logic              active,
    output logic              last
);

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  base;
        burst_cfg_t        cfg;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       at_end;

    always_comb begin
        at_end = st_q.active && (st_q.beat == offset_mask(st_q.cfg.lg));
        st_d   = st_q;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.beat   = '0;
                st_d.base   = start_col;
                st_d.cfg    = cur_cfg;
            end
        end else if (at_end) begin
            st_d.active = 1'b0;
        end else begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{active: 1'b0, beat: '0, base: '0, cfg: CFG_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign base_col = st_q.base;
    assign beat_idx = st_q.beat;
    assign run_cfg  = st_q.cfg;
    assign active   = st_q.active;
    assign last     = at_end;

    // R5: an idle start produces a beat in the next cycle
    a_r5_first_beat: assert property (@(posedge clk) disable iff (rst)
        (start && !active) |=> (active && beat_idx == '0));
    // R5: no beat in the cycle after the final one
    a_r5_gap_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !active);
    // R6: a start while running leaves the burst base untouched
    a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> (active && $stable(base_col) && $stable(run_cfg)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              busy,
    output logic              dll_pending,
    output logic              mode_err
);

    burst_cfg_t        cur_cfg;
    burst_cfg_t        run_cfg;
    logic [COL_W-1:0]  base_col;
    logic [BEAT_W-1:0] beat_idx;
    logic              active;
    logic              last;

    bcs_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk         (clk),
        .rst         (rst),
        .mode_load   (mode_load),
        .mode_word   (mode_word),
        .cfg         (cur_cfg),
        .dll_pending (dll_pending),
        .mode_err    (mode_err)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .cur_cfg   (cur_cfg),
        .base_col  (base_col),
        .beat_idx  (beat_idx),
        .run_cfg   (run_cfg),
        .active    (active),
        .last      (last)
    );

    bcs_order_gen #(.COL_W(COL_W)) u_order (
        .base_col (base_col),
        .beat_idx (beat_idx),
        .cfg      (run_cfg),
        .col      (col_addr)
    );

    assign beat_valid = active;
    assign beat_last  = last;
    assign busy       = active;

    // R2: upper column bits hold across consecutive beats of one burst
    a_r2_upper_hold: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> $stable(col_addr[COL_W-1:BEAT_W]));
    // R5: beat_last only accompanies a valid beat
    a_r5_last_valid: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);
    // R2: the first beat carries the starting column
    a_r2_first_col: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (col_addr == $past(start_col)));

endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;

    localparam int COL_W  = 12;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_load = 1'b0;
    logic [MODE_W-1:0] mode_word = '0;
    logic              start = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic [COL_W-1:0]  col_addr;
    logic              beat_valid, beat_last, busy, dll_pending, mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) uut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .col_addr(col_addr),
        .beat_valid(beat_valid), .beat_last(beat_last), .busy(busy),
        .dll_pending(dll_pending), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MODE_W-1:0] mword(input int code, input int ord, input int upper);
        return MODE_W'((upper << 7) | (ord << 3) | code);
    endfunction

    function automatic int exp_col(input int col, input int len, input int ord, input int b);
        int s, lo;
        s  = col % len;
        lo = ord ? (s ^ b) : ((s + b) % len);
        return (col - s) + lo;
    endfunction

    task automatic load(input logic [MODE_W-1:0] w);
        @(negedge clk);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    // run one burst; optional extra start or mode load at beat 1
    task automatic burst(input int col, input int len, input int ord, input string req,
                         input bit poke_start, input bit poke_mode);
        @(negedge clk);
        start     = 1'b1;
        start_col = COL_W'(col);
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < len; b++) begin
            check({req, " valid"}, beat_valid, 1);
            check({req, " col"}, col_addr, exp_col(col, len, ord, b));
            check("R5 last", beat_last, (b == len - 1));
            if (b == 0) check("R6 busy", busy, 1);
            if (b == 1 && poke_start) begin
                start = 1'b1;
                start_col = COL_W'(col ^ 12'h5a5);
            end
            if (b == 1 && poke_mode) begin
                mode_load = 1'b1;
                mode_word = mword(1, ord ^ 1, 0);
            end
            @(negedge clk);
            start = 1'b0;
            mode_load = 1'b0;
        end
        check("R5 gap", beat_valid, 0);
        check("R6 idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 valid", beat_valid, 0);
        check("R11 last", beat_last, 0);
        check("R11 busy", busy, 0);
        check("R11 dll", dll_pending, 0);
        check("R11 err", mode_err, 0);
        burst(13, 4, 0, "R11 default", 1'b0, 1'b0);

        // R1 R2 R3 R4 sweep
        for (int code = 1; code <= 3; code++) begin
            for (int ord = 0; ord < 2; ord++) begin
                load(mword(code, ord, 0));
                check("R1 err", mode_err, 0);
                for (int up = 0; up < 2; up++) begin
                    for (int k = 0; k < 8; k++) begin
                        burst(up * 12'hff8 + k, 1 << code, ord,
                              ord ? "R4 R2" : "R3 R2", 1'b0, 1'b0);
                    end
                end
            end
        end

        // R6 start while busy ignored (8 beats, interleaved)
        load(mword(3, 1, 0));
        burst(12'h3a5, 8, 1, "R6", 1'b1, 1'b0);
        // R10 mode load mid-burst does not affect the burst, takes effect next
        burst(12'h7e6, 8, 1, "R10", 1'b0, 1'b1);
        burst(12'h7e6, 2, 0, "R10 next", 1'b0, 1'b0);

        // R7 reserved length codes
        load(mword(2, 1, 0));
        for (int code = 0; code < 8; code++) begin
            if (code >= 1 && code <= 3) continue;
            load(mword(code, 0, 0));
            check("R7 err", mode_err, 1);
            burst(12'h105, 4, 1, "R7 kept", 1'b0, 1'b0);
            check("R7 err held", mode_err, 1);
        end
        load(mword(2, 0, 0));
        check("R7 cleared", mode_err, 0);

        // R8 DLL reset then normal
        load(mword(3, 0, 12'h2));
        check("R8 set", dll_pending, 1);
        check("R8 err", mode_err, 0);
        burst(12'h00b, 8, 0, "R8 len", 1'b0, 1'b0);
        // R9 reserved upper bits: rejected, flag and setting kept
        load(mword(1, 1, 12'h3));
        check("R9 err", mode_err, 1);
        check("R9 dll kept", dll_pending, 1);
        load(mword(2, 1, 12'h1));
        check("R9 err b7", mode_err, 1);
        load(mword(2, 1, 12'h6));
        check("R9 err b9", mode_err, 1);
        burst(12'h00b, 8, 0, "R9 kept", 1'b0, 1'b0);
        load(mword(2, 1, 0));
        check("R8 clear", dll_pending, 0);
        check("R8 err clr", mode_err, 0);
        burst(12'h00b, 4, 1, "R8 normal", 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule